// File: doc/BRIEF.md
# Double-Buffered Decision Output Buffer with Drain Requests

This block sits between a producer of 64-bit decision words and a DMA engine. Its storage is split into two halves. The producer writes into one half while the DMA reads out the other. The halves swap roles each time one is handed over. When a half becomes full, the block raises a one-cycle request pulse so that the DMA comes to read a burst of words.

Before a block of output starts, software-visible configuration is applied with a start pulse. The configuration has two parts: the burst field, which is the number of reads per request minus one, and the total number of words in the block. For hard decisions on a frame of F bits, with F at most 2048, the burst field would be ceil(F/64)-1.

The half size is the burst field plus one. When the block ends with a half only partly filled, that half is flushed with its own request. A status output reports how many valid words each request covers. If both halves are waiting to be drained, the producer is held off.

Top module: `pingpong_outbuf`

## Requirements
- R1: After reset, `wr_ready`, `dma_req`, `busy` and `cfg_err` are all 0.
- R2: A `start` pulse while idle whose `burst_cfg` is 0 or greater than 31 sets `cfg_err` to 1 in the following cycle and leaves `busy` at 0. A later start with a legal field (1 to 31) clears `cfg_err` and sets `busy`.
- R3: The half size is `burst_cfg`+1 words. The write that fills a half causes `dma_req` to be 1 for exactly the next cycle, with `req_words` equal to `burst_cfg`+1.
- R4: DMA reads return the accepted words in the order they were written. `rd_data` shows the word that the next read consumes, and each `rd_en` taken while a half is pending advances to the next word.
- R5: When the last word of the block lands in a partly filled half, that half is flushed. `dma_req` is 1 in the next cycle, and `req_words` equals the number of words in that half.
- R6: When the whole block fits in one half, exactly one request is raised, and it comes in the cycle after the last word is written.
- R7: While both halves hold data that is waiting to be drained, `wr_ready` is 0, and a write offered then is not stored.
- R8: A block raises ceil(total/(burst_cfg+1)) requests. `busy` falls once every word has been written and read out.
- R9: `rd_en` has no effect while no half is pending a drain.
- R10: A `start` pulse while `busy` is 1 is ignored: the configuration, `cfg_err` and the block in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latches the configuration and begins a block when idle |
| burst_cfg | input | 6 | Reads per request minus one; legal range 1 to 31 |
| total_words | input | 16 | Number of 64-bit words in the block |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | 64 | Producer word |
| wr_ready | output | 1 | Buffer can take a word this cycle |
| rd_en | input | 1 | DMA consumes the word on `rd_data` |
| rd_data | output | 64 | Next word of the pending half |
| dma_req | output | 1 | One-cycle drain request |
| req_words | output | 6 | Valid words in the half that was just requested |
| busy | output | 1 | A block is in progress |
| cfg_err | output | 1 | The last start carried an illegal burst field |

## Verification
The bench checks how the end of a block interacts with the half boundary, because this is where an error can hide:
- A design that flushes only on full halves would never request a short tail.
- A design that flushes early would raise a request before the last word of a single-half block.
- An off-by-one in the half size would shift every request by a word.

The bench delays the reads so that both halves fill at once. It then checks that a write offered then does not slip in and corrupt the read stream. It also pulses `rd_en` while nothing is pending and pulses `start` in the middle of a block. A design that honoured either pulse would move its read pointer or change its configuration, and the bench would see this as a wrong word or a wrong request count.

// File: rtl/pingpong_outbuf.sv
module pingpong_outbuf #(
  parameter int DATA_W    = 64,
  parameter int CNT_W     = 16,
  parameter int BURST_W   = 6,
  parameter int MAX_BURST = 31,
  localparam int HALF_MAX = MAX_BURST + 1,
  localparam int IDX_W    = $clog2(HALF_MAX),
  localparam int WC_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BURST_W-1:0] burst_cfg,
  input  logic [CNT_W-1:0]  total_words,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              dma_req,
  output logic [WC_W-1:0]   req_words,
  output logic              busy,
  output logic              cfg_err
);

  logic [DATA_W-1:0] mem [2*HALF_MAX];
  logic              active;
  logic [WC_W-1:0]   half_sz;
  logic [CNT_W-1:0]  total_q, wr_cnt;
  logic              wr_half, rd_half;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [1:0]        full;
  logic [WC_W-1:0]   fill [2];

  wire cfg_ok = (burst_cfg != '0) && (burst_cfg <= BURST_W'(MAX_BURST));
  wire [WC_W-1:0] wr_fill = {1'b0, wr_idx} + WC_W'(1);
  wire fill_end = (wr_fill == half_sz) || (wr_cnt + CNT_W'(1) == total_q);

  assign wr_ready = active && !full[wr_half] && (wr_cnt != total_q);
  wire wr_fire = wr_valid && wr_ready;
  wire rd_fire = rd_en && full[rd_half];
  wire rd_last = ({1'b0, rd_idx} + WC_W'(1)) == fill[rd_half];

  assign rd_data = mem[{rd_half, rd_idx}];
  assign busy    = active;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[{wr_half, wr_idx}] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cfg_err   <= 1'b0;
      half_sz   <= '0;
      total_q   <= '0;
      wr_cnt    <= '0;
      wr_half   <= 1'b0;
      wr_idx    <= '0;
      rd_half   <= 1'b0;
      rd_idx    <= '0;
      full      <= 2'b00;
      fill[0]   <= '0;
      fill[1]   <= '0;
      dma_req   <= 1'b0;
      req_words <= '0;
    end else begin
      dma_req <= 1'b0;
      if (start && !active) begin
        cfg_err <= !cfg_ok;
        active  <= cfg_ok;
        half_sz <= WC_W'(burst_cfg) + WC_W'(1);
        total_q <= total_words;
        wr_cnt  <= '0;
        wr_half <= 1'b0;
        wr_idx  <= '0;
        rd_half <= 1'b0;
        rd_idx  <= '0;
      end else if (active && wr_cnt == total_q && full == 2'b00) begin
        active <= 1'b0;
      end
      if (wr_fire) begin
        wr_cnt <= wr_cnt + CNT_W'(1);
        if (fill_end) begin
          full[wr_half] <= 1'b1;
          fill[wr_half] <= wr_fill;
          wr_half       <= ~wr_half;
          wr_idx        <= '0;
          dma_req       <= 1'b1;
          req_words     <= wr_fill;
        end else begin
          wr_idx <= wr_idx + IDX_W'(1);
        end
      end
      if (rd_fire) begin
        if (rd_last) begin
          full[rd_half] <= 1'b0;
          rd_half       <= ~rd_half;
          rd_idx        <= '0;
        end else begin
          rd_idx <= rd_idx + IDX_W'(1);
        end
      end
    end
  end

endmodule

module pingpong_outbuf_chk #(
  parameter int IDX_W    = 5,
  parameter int WC_W     = 6,
  parameter int HALF_MAX = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic            rd_en,
  input logic            dma_req,
  input logic [WC_W-1:0] req_words,
  input logic            busy,
  input logic            cfg_err,
  input logic [1:0]      full,
  input logic [IDX_W-1:0] rd_idx
);
  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !wr_ready); // R1
  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |-> !busy); // R2
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |-> !dma_req); // R2
  AST_REQ_WORDS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) dma_req |-> (req_words != '0 && req_words <= WC_W'(HALF_MAX))); // R3
  AST_REQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) dma_req |-> $past(wr_valid && wr_ready)); // R6
  AST_STALL_BOTH_FULL: assert property (@(posedge clk) disable iff (!rst_n) (&full) |-> !wr_ready); // R7
  AST_IDLE_READ_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && full == 2'b00) |=> $stable(rd_idx)); // R9
endmodule

bind pingpong_outbuf pingpong_outbuf_chk #(.IDX_W(IDX_W), .WC_W(WC_W), .HALF_MAX(HALF_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_en(rd_en),
  .dma_req(dma_req), .req_words(req_words), .busy(busy), .cfg_err(cfg_err),
  .full(full), .rd_idx(rd_idx)
);

// File: tb/pingpong_outbuf_tb_top.sv
module pingpong_outbuf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  burst_cfg = '0;
  logic [15:0] total_words = '0;
  logic        wr_valid = 1'b0;
  logic [63:0] wr_data = '0;
  logic        wr_ready;
  logic        rd_en = 1'b0;
  logic [63:0] rd_data;
  logic        dma_req;
  logic [5:0]  req_words;
  logic        busy;
  logic        cfg_err;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pingpong_outbuf dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_cfg(burst_cfg), .total_words(total_words),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .rd_en(rd_en), .rd_data(rd_data),
    .dma_req(dma_req), .req_words(req_words), .busy(busy), .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_reqs(input int total, input int half);
    return (total + half - 1) / half;
  endfunction

  task automatic run_block(input int burst, input int total, input int wr_pct,
                           input int rd_pct, input int rd_delay, input bit poke);
    logic [63:0] sent[$];
    int reqq[$];
    int half = burst + 1;
    int accepted = 0, rd_cnt = 0, granted = 0, reqs = 0, front_left = 0;
    int last_bound = 0, exp_words = 0, n = 0, stalls = 0;
    bit exp_req = 0, first_req_seen = 0;
    @(negedge clk);
    start = 1'b1; burst_cfg = 6'(burst); total_words = 16'(total);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && cfg_err == 1'b0, "R2 legal start", {busy, cfg_err}, 2'b10);
    while (!(accepted == total && rd_cnt == total) && n < 5000) begin
      chk(dma_req == exp_req, "R3/R5 request timing", dma_req, exp_req);
      if (dma_req) begin
        chk(req_words == 6'(exp_words), "R3/R5 req_words", req_words, exp_words);
        if (!first_req_seen && total <= half)
          chk(accepted == total, "R6 single request after last word", accepted, total);
        first_req_seen = 1;
        reqq.push_back(int'(req_words));
        granted += int'(req_words);
        reqs++;
      end
      if (reqq.size() == 2) begin
        stalls++;
        chk(wr_ready == 1'b0, "R7 stall both halves pending", wr_ready, 0);
      end
      if (poke && n == 4) begin
        start = 1'b1; burst_cfg = 6'd0; total_words = 16'd3;
      end else begin
        start = 1'b0;
      end
      if (poke && n == 5)
        chk(cfg_err == 1'b0 && busy == 1'b1, "R10 start while busy ignored", {busy, cfg_err}, 2'b10);
      exp_req = 0;
      wr_valid = ($urandom_range(99) < wr_pct);
      wr_data = {$urandom, $urandom};
      if (wr_valid && wr_ready) begin
        sent.push_back(wr_data);
        accepted++;
        if (accepted - last_bound == half || accepted == total) begin
          exp_req = 1;
          exp_words = accepted - last_bound;
          last_bound = accepted;
        end
      end
      rd_en = (n >= rd_delay) && ($urandom_range(99) < rd_pct);
      if (rd_en && rd_cnt < granted) begin
        chk(rd_data == sent[rd_cnt], "R4 read order", rd_data, sent[rd_cnt]);
        rd_cnt++;
        if (front_left == 0) front_left = reqq[0];
        front_left--;
        if (front_left == 0) void'(reqq.pop_front());
      end
      n++;
      @(negedge clk);
    end
    wr_valid = 1'b0; rd_en = 1'b0; start = 1'b0;
    chk(n < 5000, "R8 block completes", n, 5000);
    chk(dma_req == exp_req, "R3/R5 final request timing", dma_req, exp_req);
    if (dma_req) begin reqs++; chk(req_words == 6'(exp_words), "R5 final req_words", req_words, exp_words); end
    @(negedge clk);
    chk(busy == 1'b0, "R8 busy falls after drain", busy, 0);
    chk(reqs == exp_reqs(total, half), "R8 request count", reqs, exp_reqs(total, half));
    if (total <= half) chk(reqs == 1, "R6 one request", reqs, 1);
    if (rd_delay > 40 && total > 2 * half) chk(stalls > 0, "R7 stall reached", stalls, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(wr_ready == 0 && dma_req == 0 && busy == 0 && cfg_err == 0, "R1 reset state",
        {wr_ready, dma_req, busy, cfg_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready == 0 && dma_req == 0 && busy == 0 && cfg_err == 0, "R1 idle after reset",
        {wr_ready, dma_req, busy, cfg_err}, 0);

    start = 1'b1; burst_cfg = 6'd0; total_words = 16'd8;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err == 1 && busy == 0, "R2 burst 0 rejected", {cfg_err, busy}, 2'b10);
    start = 1'b1; burst_cfg = 6'd40;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err == 1 && busy == 0 && dma_req == 0, "R2 burst 40 rejected", {cfg_err, busy}, 2'b10);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;

    run_block(31, 10, 100, 100, 0, 0);
    run_block(3, 4, 100, 100, 0, 0);
    run_block(3, 22, 100, 50, 60, 0);
    run_block(1, 7, 80, 80, 0, 1);
    run_block(31, 32, 100, 100, 0, 0);
    run_block(31, 33, 100, 100, 0, 0);
    run_block(5, 1, 100, 100, 0, 0);
    for (int i = 0; i < 20; i++)
      run_block($urandom_range(1, 31), $urandom_range(1, 120), $urandom_range(30, 100),
                $urandom_range(20, 100), $urandom_range(0, 80), (i % 4) == 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule